// File: doc/BRIEF.md
# Masked circular address generator

This block forms the memory operand address for multiply-accumulate instructions that also move data. Each request carries the current address-register value, a 2-bit addressing-mode code, a sign-extended 16-bit displacement and a per-instruction mask-enable bit. From these the block produces the operand address that goes to the bus and, for the auto-update modes, the new value to be written back into the address register.

When masking is enabled, the result is ANDed with an effective mask. The effective mask has all ones in the upper half and the programmable 16-bit mask value in the lower half. Clearing a group of mask bits confines the pointer to an aligned region, so a post-increment walk through a buffer wraps around on its own and a circular queue needs no extra address logic. The mask lives in a register that software writes and reads through a simple 32-bit port. Only the low 16 bits are stored.

Results appear one clock after the request, together with a result-valid flag and a write-back-valid flag.

Top module: `masked_addr_gen`

## Requirements
- R1: After reset, `mask_rd_data` reads 32'hFFFFFFFF, and `rsp_valid` and `rsp_wb_valid` are 0.
- R2: A cycle with `mask_wr_en` high stores `mask_wr_data[15:0]` into the mask register. From the next cycle on, `mask_rd_data` returns the stored 16 bits in [15:0] with bits [31:16] all ones, whatever the upper written bits were.
- R3: With `req_mask_en` = 0, every mode computes its addresses with no masking:
  - indirect gives `req_areg`;
  - post-increment gives `req_areg`, with write-back `req_areg`+4;
  - pre-decrement gives `req_areg`-4 for both outputs;
  - displacement gives `req_areg` + sign-extended `req_disp`.
- R4: Mode 2'b00 (register indirect) with masking gives an operand address of `req_areg` AND {16'hFFFF, mask}, and no write-back.
- R5: Mode 2'b01 (post-increment) gives an operand address equal to the unmasked `req_areg`. Its write-back value is (`req_areg`+4) AND the effective mask.
- R6: Mode 2'b10 (pre-decrement) gives an operand address and a write-back value that are both (`req_areg`-4) AND the effective mask.
- R7: Mode 2'b11 (displacement) gives an operand address of (`req_areg` + sign-extended 16-bit `req_disp`) AND the effective mask, and no write-back. A displacement with bit 15 set is treated as negative.
- R8: `rsp_wb_valid` is 1 only in a cycle where `rsp_valid` is 1 and the request was post-increment or pre-decrement.
- R9: `rsp_valid` equals `req_valid` delayed by exactly one clock. The address outputs update only for a valid request and hold their values otherwise.
- R10: A mask write and a request in the same cycle compute the address with the mask value held before that write.
- R11: Addition and subtraction use the full 32-bit width, so carries and borrows cross bit 16 and wrap at the top of the address space. The upper 16 bits are never cleared by the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 32 | Write data; only [15:0] is stored |
| mask_rd_data | output | 32 | Mask readback, upper half forced to ones |
| req_valid | input | 1 | Address request valid |
| req_areg | input | 32 | Current address-register value |
| req_mode | input | 2 | 00 indirect, 01 post-increment, 10 pre-decrement, 11 displacement |
| req_disp | input | 16 | Signed 16-bit displacement |
| req_mask_en | input | 1 | Apply the mask to this request |
| rsp_valid | output | 1 | Result valid, one clock after `req_valid` |
| rsp_oper_addr | output | 32 | Operand address for the bus |
| rsp_wb_valid | output | 1 | Updated address-register value is valid |
| rsp_wb_addr | output | 32 | Updated address-register value |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit mask, a 16-bit displacement and a step of 4. With these values the tests can reach a carry out of the masked half into bit 16, a borrow from address zero that wraps to the top of the space, and negative displacements that cross a mask boundary. The stimulus writes mask values that have nonzero upper data bits, so the readback shows that those bits are dropped. Back-to-back requests, idle cycles and a mask write in the same cycle as a request show that the output stage holds its values and uses the old mask.

// File: rtl/mag_pkg.sv
package mag_pkg;

  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_POST = 2'b01,
    MODE_PRE  = 2'b10,
    MODE_DISP = 2'b11
  } mag_mode_e;

  localparam int unsigned MAG_ADDR_W = 32;
  localparam int unsigned MAG_MASK_W = 16;
  localparam int unsigned MAG_DISP_W = 16;
  localparam int unsigned MAG_STEP   = 4;

  function automatic logic mode_writes_back(input mag_mode_e m);
    return (m == MODE_POST) || (m == MODE_PRE);
  endfunction

endpackage

// File: rtl/mag_rst_sync.sv
module mag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mag_mask_reg.sv
module mag_mask_reg #(
  parameter int unsigned ARCH_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_data,
  output logic [MASK_W-1:0] mask,
  output logic [ARCH_W-1:0] rd_data
);

  localparam int unsigned PAD_W = ARCH_W - MASK_W;

  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      mask_d = wr_data[MASK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask    = mask_q;
  assign rd_data = {{PAD_W{1'b1}}, mask_q};

endmodule

// File: rtl/mag_addr_calc.sv
module mag_addr_calc
  import mag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned STEP   = 4
) (
  input  logic [ADDR_W-1:0] areg,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask,
  output logic [ADDR_W-1:0] oper_addr,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wb_en
);

  localparam int unsigned     EXT_W  = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] eff_mask;
  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] sum_inc;
  logic [ADDR_W-1:0] sum_dec;
  logic [ADDR_W-1:0] sum_disp;
  mag_mode_e         mode_e;

  // Only the low MASK_W bits are programmable; the rest pass unchanged.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i < MASK_W) begin : g_low
      assign eff_mask[i] = mask[i] | ~mask_en;
    end else begin : g_high
      assign eff_mask[i] = 1'b1;
    end
  end

  assign disp_sx  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign sum_inc  = areg + STEP_V;
  assign sum_dec  = areg - STEP_V;
  assign sum_disp = areg + disp_sx;
  assign mode_e   = mag_mode_e'(mode);

  always_comb begin
    oper_addr = areg & eff_mask;
    wb_addr   = areg;
    unique case (mode_e)
      MODE_IND: begin
        oper_addr = areg & eff_mask;
      end
      MODE_POST: begin
        oper_addr = areg;
        wb_addr   = sum_inc & eff_mask;
      end
      MODE_PRE: begin
        oper_addr = sum_dec & eff_mask;
        wb_addr   = sum_dec & eff_mask;
      end
      MODE_DISP: begin
        oper_addr = sum_disp & eff_mask;
      end
      default: begin
        oper_addr = areg & eff_mask;
      end
    endcase
    wb_en = mode_writes_back(mode_e);
  end

endmodule

// File: rtl/mag_out_stage.sv
module mag_out_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_oper,
  input  logic [ADDR_W-1:0] in_wb,
  input  logic              in_wb_en,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_oper,
  output logic              out_wb_valid,
  output logic [ADDR_W-1:0] out_wb
);

  logic              vld_q,  vld_d;
  logic              wbv_q,  wbv_d;
  logic [ADDR_W-1:0] oper_q, oper_d;
  logic [ADDR_W-1:0] wb_q,   wb_d;
  logic              addr_ce;

  assign addr_ce = in_valid;

  always_comb begin
    vld_d  = in_valid;
    wbv_d  = in_valid & in_wb_en;
    oper_d = in_oper;
    wb_d   = in_wb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wbv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      wbv_q <= wbv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oper_q <= '0;
      wb_q   <= '0;
    end else if (addr_ce) begin
      oper_q <= oper_d;
      wb_q   <= wb_d;
    end
  end

  assign out_valid    = vld_q;
  assign out_wb_valid = wbv_q;
  assign out_oper     = oper_q;
  assign out_wb       = wb_q;

endmodule

// File: rtl/masked_addr_gen.sv
module masked_addr_gen
  import mag_pkg::*;
#(
  parameter int unsigned ADDR_W = MAG_ADDR_W,
  parameter int unsigned MASK_W = MAG_MASK_W,
  parameter int unsigned DISP_W = MAG_DISP_W,
  parameter int unsigned STEP   = MAG_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_en,
  input  logic [ADDR_W-1:0] mask_wr_data,
  output logic [ADDR_W-1:0] mask_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_areg,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_mask_en,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_oper_addr,
  output logic              rsp_wb_valid,
  output logic [ADDR_W-1:0] rsp_wb_addr
);

  logic              rst_sync_n;
  logic [MASK_W-1:0] mask_cur;
  logic [ADDR_W-1:0] calc_oper;
  logic [ADDR_W-1:0] calc_wb;
  logic              calc_wb_en;

  mag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mag_mask_reg #(.ARCH_W(ADDR_W), .MASK_W(MASK_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask    (mask_cur),
    .rd_data (mask_rd_data)
  );

  mag_addr_calc #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W),
    .DISP_W (DISP_W),
    .STEP   (STEP)
  ) u_calc (
    .areg      (req_areg),
    .mode      (req_mode),
    .disp      (req_disp),
    .mask_en   (req_mask_en),
    .mask      (mask_cur),
    .oper_addr (calc_oper),
    .wb_addr   (calc_wb),
    .wb_en     (calc_wb_en)
  );

  mag_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .in_valid     (req_valid),
    .in_oper      (calc_oper),
    .in_wb        (calc_wb),
    .in_wb_en     (calc_wb_en),
    .out_valid    (rsp_valid),
    .out_oper     (rsp_oper_addr),
    .out_wb_valid (rsp_wb_valid),
    .out_wb       (rsp_wb_addr)
  );

endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr_en,
  input logic [ADDR_W-1:0] mask_wr_data,
  input logic [ADDR_W-1:0] mask_rd_data,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_areg,
  input logic [1:0]        req_mode,
  input logic              req_mask_en,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_oper_addr,
  input logic              rsp_wb_valid
);

  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_rd_data[MASK_W-1:0] == $past(mask_wr_data[MASK_W-1:0]));

  p_mask_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    &mask_rd_data[ADDR_W-1:MASK_W]);

  p_nomask_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mask_en && req_mode == 2'b00) |=> rsp_oper_addr == $past(req_areg));

  p_post_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'b01) |=> rsp_oper_addr == $past(req_areg));

  p_wb_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wb_valid |-> rsp_valid);

  p_no_wb_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == 2'b00 || req_mode == 2'b11)) |=> !rsp_wb_valid);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_oper_addr));

endmodule

bind masked_addr_gen mag_checker #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .mask_wr_en    (mask_wr_en),
  .mask_wr_data  (mask_wr_data),
  .mask_rd_data  (mask_rd_data),
  .req_valid     (req_valid),
  .req_areg      (req_areg),
  .req_mode      (req_mode),
  .req_mask_en   (req_mask_en),
  .rsp_valid     (rsp_valid),
  .rsp_oper_addr (rsp_oper_addr),
  .rsp_wb_valid  (rsp_wb_valid)
);

// File: tb/tb_masked_addr_gen.sv
module tb_masked_addr_gen;

  logic        clk;
  logic        rst_n;
  logic        mask_wr_en;
  logic [31:0] mask_wr_data;
  logic [31:0] mask_rd_data;
  logic        req_valid;
  logic [31:0] req_areg;
  logic [1:0]  req_mode;
  logic [15:0] req_disp;
  logic        req_mask_en;
  logic        rsp_valid;
  logic [31:0] rsp_oper_addr;
  logic        rsp_wb_valid;
  logic [31:0] rsp_wb_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  masked_addr_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mask_wr_en    (mask_wr_en),
    .mask_wr_data  (mask_wr_data),
    .mask_rd_data  (mask_rd_data),
    .req_valid     (req_valid),
    .req_areg      (req_areg),
    .req_mode      (req_mode),
    .req_disp      (req_disp),
    .req_mask_en   (req_mask_en),
    .rsp_valid     (rsp_valid),
    .rsp_oper_addr (rsp_oper_addr),
    .rsp_wb_valid  (rsp_wb_valid),
    .rsp_wb_addr   (rsp_wb_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] m;
    logic [1:0]  mode;
    logic        men;
    logic [31:0] areg;
    logic [15:0] disp;
    logic [31:0] oa;
    logic        wbv;
    logic [31:0] wb;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'hFFFF, 2'b00, 1'b1, 32'h12345678, 16'h0000, 32'h12345678, 1'b0, 32'h0, 8'd4},  // R4
    '{16'h00FF, 2'b00, 1'b1, 32'h10000A5C, 16'h0000, 32'h1000005C, 1'b0, 32'h0, 8'd4},  // R4
    '{16'h00FF, 2'b00, 1'b0, 32'h10000A5C, 16'h0000, 32'h10000A5C, 1'b0, 32'h0, 8'd3},  // R3
    '{16'h00FF, 2'b01, 1'b1, 32'h200000FC, 16'h0000, 32'h200000FC, 1'b1, 32'h20000000, 8'd5}, // R5
    '{16'h00FF, 2'b01, 1'b0, 32'h200000FC, 16'h0000, 32'h200000FC, 1'b1, 32'h20000100, 8'd3}, // R3
    '{16'h00FF, 2'b10, 1'b1, 32'h20000000, 16'h0000, 32'h1FFF00FC, 1'b1, 32'h1FFF00FC, 8'd6}, // R6
    '{16'h0FF0, 2'b11, 1'b1, 32'h00003000, 16'h0010, 32'h00000010, 1'b0, 32'h0, 8'd7},  // R7
    '{16'h0FF0, 2'b11, 1'b1, 32'h00003000, 16'hFFF0, 32'h00000FF0, 1'b0, 32'h0, 8'd7},  // R7
    '{16'h0FF0, 2'b11, 1'b0, 32'h00003000, 16'hFFF0, 32'h00002FF0, 1'b0, 32'h0, 8'd3},  // R3
    '{16'h0000, 2'b01, 1'b1, 32'h0001FFFC, 16'h0000, 32'h0001FFFC, 1'b1, 32'h00020000, 8'd11}, // R11
    '{16'hFFFF, 2'b10, 1'b1, 32'h00000000, 16'h0000, 32'hFFFFFFFC, 1'b1, 32'hFFFFFFFC, 8'd11}, // R11
    '{16'hFFFF, 2'b01, 1'b0, 32'hFFFFFFFC, 16'h0000, 32'hFFFFFFFC, 1'b1, 32'h00000000, 8'd11}, // R11
    '{16'h0000, 2'b00, 1'b1, 32'hABCD1234, 16'h0000, 32'hABCD0000, 1'b0, 32'h0, 8'd4}   // R4
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mask_wr_en   = 1'b0;
    mask_wr_data = 32'h0;
    req_valid    = 1'b0;
    req_areg     = 32'h0;
    req_mode     = 2'b00;
    req_disp     = 16'h0;
    req_mask_en  = 1'b0;
  endtask

  task automatic write_mask(input logic [15:0] m);
    @(negedge clk);
    mask_wr_en   = 1'b1;
    mask_wr_data = {16'h5A5A, m};
    @(negedge clk);
    mask_wr_en   = 1'b0;
    chk("R2 mask readback", mask_rd_data, {16'hFFFF, m});
  endtask

  task automatic issue(input logic [1:0] mode, input logic men,
                       input logic [31:0] areg, input logic [15:0] disp);
    @(negedge clk);
    req_valid   = 1'b1;
    req_mode    = mode;
    req_mask_en = men;
    req_areg    = areg;
    req_disp    = disp;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mask after reset", mask_rd_data, 32'hFFFFFFFF);
    chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R1 rsp_wb_valid after reset", {31'h0, rsp_wb_valid}, 32'h0);

    // Table walk: R3 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      write_mask(VEC[v].m);
      issue(VEC[v].mode, VEC[v].men, VEC[v].areg, VEC[v].disp);
      chk({tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
      chk({tag, " oper"}, rsp_oper_addr, VEC[v].oa);
      chk({tag, " R8 wb_valid"}, {31'h0, rsp_wb_valid}, {31'h0, VEC[v].wbv});
      if (VEC[v].wbv) chk({tag, " wb"}, rsp_wb_addr, VEC[v].wb);
    end

    // R9: idle cycle drops valid and holds the address
    @(negedge clk);
    chk("R9 valid drops", {31'h0, rsp_valid}, 32'h0);
    chk("R9 oper held", rsp_oper_addr, 32'hABCD0000);
    chk("R8 no wb when idle", {31'h0, rsp_wb_valid}, 32'h0);

    // R9: back-to-back requests, one result per cycle
    write_mask(16'hFFFF);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'b00; req_mask_en = 1'b1; req_areg = 32'h00000100;
    @(negedge clk);
    chk("R9 b2b first", rsp_oper_addr, 32'h00000100);
    req_areg = 32'h00000200;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 b2b second", rsp_oper_addr, 32'h00000200);
    chk("R9 b2b valid", {31'h0, rsp_valid}, 32'h1);

    // R10: same-cycle mask write uses the old mask
    write_mask(16'h00FF);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = 32'hFFFF0000;
    req_valid = 1'b1; req_mode = 2'b00; req_mask_en = 1'b1; req_areg = 32'h00001234;
    @(negedge clk);
    mask_wr_en = 1'b0; req_valid = 1'b0;
    chk("R10 old mask used", rsp_oper_addr, 32'h00000034);
    chk("R10 new mask stored", mask_rd_data, 32'hFFFF0000);

    // R1: reset in mid-run restores the mask
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mask on reset", mask_rd_data, 32'hFFFFFFFF);
    chk("R1 valid on reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule